// File: doc/BRIEF.md
# Transposed 18-Tap FIR Filter with Shared Constant Multiplier

This block is a fixed-coefficient FIR filter with eighteen taps, built in transposed form. On every clock edge it accepts one signed 8-bit sample. One shift-add network multiplies that sample by all eighteen coefficients at once. The shifted copies of the sample are built once and every coefficient draws on them, so the block has no general-purpose multiplier.

The eighteen products enter a chain of seventeen accumulation registers. The product for the last tap goes into the register at the far end of the chain. Each register passes its partial sum toward the output and adds the product of its own tap on the way. The product for tap 0 closes the sum into the output register. The longest path is therefore one constant product plus one 33-bit addition, for any number of taps.

The block is used as a streaming filter with one sample per clock. The result appears one clock after the sample that completes it. A synchronous reset empties the whole history.

Top module: `tfir_mcm`

## Requirements
- R1: While `rst_i` is high at a rising edge, `y_o` becomes 0 and every accumulation register becomes 0. After reset is released, no sample taken before the reset contributes to any output.
- R2: The filter output has a latency of one clock. After the rising edge that takes sample x[n], `y_o` equals Σ h[k]·x[n−k] for k = 0..17.
- R3: The default coefficients h0..h17 are 3, −7, 12, −19, 27, −36, 45, −54, 120, −127, 58, −41, 33, −25, 18, −11, 6, −2. They are packed into `COEFS` with h[k] at bits [8k+7:8k]. A single sample of value 1 surrounded by zeros produces these values on `y_o` on eighteen consecutive clocks, in index order, and 0 afterwards.
- R4: Samples and coefficients are signed two's complement. Each product fits in 15 bits and is sign-extended to 33 bits before it is added. This holds for the extreme sample values −128 and 127.
- R5: After reset, the first seventeen outputs are computed as if all earlier samples were 0. In particular, the first output equals h0 times the first sample.
- R6: When the newest product and the oldest contribution in the chain land in the same output, both are summed. Two unit impulses 17 samples apart give h17 + h0 on that clock.
- R7: For arbitrary sample streams, `y_o` matches the convolution of the stream with h0..h17 on every clock.
- R8: `|y_o|` never exceeds 128·Σ|h[k]|. The 33-bit accumulation never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one sample is taken per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| x_i | input | 8 | Signed input sample |
| y_o | output | 33 | Registered signed filter result |

## Verification
The product of the newest sample for tap 0 and the contribution of the oldest sample for tap 17 come together in the same output cycle. The bench provokes this with two unit impulses placed seventeen samples apart. It expects exactly h0 + h17 on the clock the second impulse is taken, and any dropped or double-counted chain stage changes that value. The bench also asserts reset while a nonzero sample is present. Fresh impulses after the reset must then show a zero history.

// File: rtl/tfir_mcm.sv
module tfir_mcm #(
  parameter int NT = 18,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int PW = 15,
  parameter int AW = 33,
  parameter logic [NT*CW-1:0] COEFS = {
    8'hFE, 8'h06, 8'hF5, 8'h12, 8'hE7, 8'h21, 8'hD7, 8'h3A, 8'h81,
    8'h78, 8'hCA, 8'h2D, 8'hDC, 8'h1B, 8'hED, 8'h0C, 8'hF9, 8'h03}
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [AW-1:0] y_o
);

  function automatic int abs_sum();
    int s = 0;
    for (int k = 0; k < NT; k++) begin
      int c = int'($signed(COEFS[k*CW +: CW]));
      s += (c < 0) ? -c : c;
    end
    return s;
  endfunction

  localparam int MB = CW - 1;
  localparam logic signed [AW-1:0] YMAX = AW'(abs_sum() * (2 ** (DW - 1)));
  localparam logic signed [CW-1:0] H0 = COEFS[CW-1:0];

  logic signed [PW-1:0] xs;
  logic signed [PW-1:0] shf  [MB];
  logic signed [AW-1:0] pe   [NT];
  logic signed [AW-1:0] z    [1:NT-1];

  assign xs = {{(PW-DW){x_i[DW-1]}}, x_i};

  for (genvar b = 0; b < MB; b++) begin : g_shift
    assign shf[b] = xs <<< b;
  end

  for (genvar k = 0; k < NT; k++) begin : g_tap
    localparam logic signed [CW-1:0] C = COEFS[k*CW +: CW];
    localparam int MAG = (C < 0) ? -int'(C) : int'(C);
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] prod;
    always_comb begin
      acc = '0;
      for (int b = 0; b < MB; b++)
        if (MAG[b]) acc = acc + shf[b];
    end
    assign prod  = (C < 0) ? -acc : acc;
    assign pe[k] = {{(AW-PW){prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 1; k < NT; k++) z[k] <= '0;
      y_o <= '0;
    end else begin
      z[NT-1] <= pe[NT-1];
      for (int k = 1; k < NT-1; k++) z[k] <= pe[k] + z[k+1];
      y_o <= pe[0] + z[1];
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (y_o == '0));

  // R5
  first_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |=> (y_o == H0 * $past(x_i)));

  // R2
  tail_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$fell(rst_i) && $past(x_i) == '0) |-> (z[NT-1] == '0));

  // R8
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (y_o <= YMAX) && (y_o >= -YMAX));

endmodule

// File: tb/sim_tfir_mcm.sv
module sim_tfir_mcm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [7:0]  x = '0;
  logic signed [32:0] y;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int hist [18];

  always #4 clk = ~clk;

  tfir_mcm u0 (.clk_i(clk), .rst_i(rst), .x_i(x), .y_o(y));

  function automatic int coef(int k);
    case (k)
      0: return 3;    1: return -7;   2: return 12;   3: return -19;
      4: return 27;   5: return -36;  6: return 45;   7: return -54;
      8: return 120;  9: return -127; 10: return 58;  11: return -41;
      12: return 33;  13: return -25; 14: return 18;  15: return -11;
      16: return 6;   default: return -2;
    endcase
  endfunction

  function automatic longint conv();
    longint s = 0;
    for (int k = 0; k < 18; k++) s += longint'(coef(k)) * longint'(hist[k]);
    return s;
  endfunction

  task automatic check(string req, longint exp);
    logic signed [32:0] e;
    e = 33'(exp);
    checks++;
    if (y !== e) begin
      errors++;
      $display("FAIL %s: y=%0d expected=%0d", req, y, e);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < 18; k++) hist[k] = 0;
  endtask

  task automatic push(int v, string req);
    for (int k = 17; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    x = 8'(v);
    @(negedge clk);
    check(req, conv());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: y=%0d expected=finished", y);
    finish_run();
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    check("R1 reset state", 0);
    rst = 1'b0;

    // R5: first output uses zero history
    push(-5, "R5 first output");
    // R3 impulse response in order
    clear_hist();
    rst = 1'b1; x = '0; @(negedge clk); check("R1 reset", 0); rst = 1'b0;
    push(1, "R3 impulse h0");
    for (int i = 1; i < 18; i++) begin
      push(0, "R3 impulse tap");
      checks++;
      if (y !== 33'(coef(i))) begin
        errors++;
        $display("FAIL R3 tap %0d: y=%0d expected=%0d", i, y, coef(i));
      end
    end
    repeat (3) push(0, "R3 tail zero");

    // R4 extremes
    push(-128, "R4 minus 128");
    repeat (17) push(0, "R4 minus 128 tail");
    repeat (20) push(127, "R4 plus 127 run");
    repeat (20) push(-128, "R4 minus 128 run");
    for (int i = 0; i < 20; i++) push((i % 2) ? 127 : -128, "R8 alternating extremes");

    // R6 collision of newest and oldest contributions
    repeat (18) push(0, "R6 flush");
    push(1, "R6 first impulse");
    repeat (16) push(0, "R6 gap");
    push(1, "R6 coincidence");
    checks++;
    if (y !== 33'(coef(0) + coef(17))) begin
      errors++;
      $display("FAIL R6: y=%0d expected=%0d", y, coef(0) + coef(17));
    end

    // R1 reset in mid-stream with nonzero input
    repeat (5) push(77, "R7 prefill");
    rst = 1'b1; x = 8'sd99;
    @(negedge clk);
    check("R1 mid reset", 0);
    clear_hist();
    rst = 1'b0;
    for (int i = 0; i < 17; i++) push(1, "R5 zero history after reset");

    // R7 random stream
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) push(int'($signed(8'($urandom))), "R7 random");
    for (int i = 0; i < 100; i++) push(int'($signed(8'($urandom % 3))) - 1, "R2 small values");

    finish_run();
  end
endmodule